// File: doc/BRIEF.md
# Quad Prescaled Pulse-Width Modulator

This block drives four independent pulse-width-modulated outputs. Each channel keeps a single 32-bit configuration word that holds an enable flag, an 8-bit duty value and a 13-bit clock-divide value. The channel divides the system clock by the programmed divide value plus one. Each divided tick advances an 8-bit period counter, so one PWM period is always 256 ticks long. The output stays high while the period counter is below the duty value.

Software reaches the four words through a plain register port with a byte address, write data, a write strobe, a read strobe and registered read data. Channel words sit 16 bytes apart, so address bits [5:4] select the channel and bits [3:0] are ignored. A read returns the stored word, which lets software toggle only the enable flag through read-modify-write.

New duty and divide values written to a running channel are held back until the current period ends. This keeps the output free of glitches. Setting the enable flag on a stopped channel starts a full-length period from zero.

Top module: `quad_pwm`

## Requirements
- R1: After a synchronous active-high reset, all four configuration words read as zero, every PWM output is low and the read data is zero.
- R2: Address bits [5:4] select the channel and address bits [3:0] are ignored. A write to one channel leaves the other three channels' words unchanged.
- R3: Bit 31 of a channel word is the enable flag. From the cycle after a write that clears it, that channel's output is low.
- R4: Bits [12:0] are the divide field D. The period counter advances once every D+1 clock cycles, so one period lasts 256×(D+1) cycles. D=0 advances the counter on every clock.
- R5: Bits [23:16] are the duty field N. Each period starts high and holds the output high for N×(D+1) cycles, then low for the rest of the period.
- R6: A duty of 0 keeps the output low for the whole period. A duty of 255 gives 255×(D+1) high cycles followed by D+1 low cycles.
- R7: Writing the value zero to a channel disables it and clears its duty and divide fields. A later read of that channel returns zero.
- R8: A read strobe in cycle k places the addressed channel's stored word on the read data in cycle k+1. If a write to the same channel happens in cycle k, the read returns the word as it was before that write.
- R9: Bits 30:24 and 15:13 of a channel word ignore writes and always read as zero.
- R10: When the enable flag goes from clear to set, the output is low for one cycle. The channel then starts a fresh period with the divider and period counter at zero, so the first period is full length.
- R11: If a channel is running when duty or divide values are written, the current period finishes with the old values. The new values apply from the next period.
- R12: While the read strobe is low, the read data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (6) | Byte address; bits [5:4] pick the channel |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | NUM_CH (4) | One PWM output per channel |

## Verification
On every clock, the embedded assertions check the following: the divider count never passes its limit and returns to zero after each tick; the period counter only moves on a tick; a restarted channel begins at count zero; the duty and divide shadows change only at a period wrap; a zero write clears the addressed word; and the read data holds while no read is strobed. The bench scenarios show the behaviours that only appear over a whole period. These are the high-cycle count for several duty and divide settings, the duty extremes 0 and 255, the deferral of a mid-period duty change, the full first period after a re-enable, field masking through read-back, and read-modify-write of the enable flag alone.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;

  localparam int WORD_W     = 32;
  localparam int EN_POS     = 31;
  localparam int DUTY_LSB   = 16;
  localparam int DUTY_W     = 8;
  localparam int DIV_LSB    = 0;
  localparam int DIV_W      = 13;
  localparam int STRIDE_LSB = 4;

  typedef struct packed {
    logic              en;
    logic [DUTY_W-1:0] duty;
    logic [DIV_W-1:0]  div;
  } chan_cfg_t;

  function automatic chan_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
    chan_cfg_t c;
    c.en   = w[EN_POS];
    c.duty = w[DUTY_LSB +: DUTY_W];
    c.div  = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] cfg_to_word(input chan_cfg_t c);
    logic [WORD_W-1:0] w;
    w                      = '0;
    w[EN_POS]              = c.en;
    w[DUTY_LSB +: DUTY_W]  = c.duty;
    w[DIV_LSB +: DIV_W]    = c.div;
    return w;
  endfunction

endpackage

// File: rtl/qpwm_regbank.sv
module qpwm_regbank
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     wr_en,
  input  logic                     rd_en,
  output logic [WORD_W-1:0]        rd_data,
  output chan_cfg_t [NUM_CH-1:0]   cfg_o
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0] sel;
  logic            sel_ok;
  logic            unused_addr;

  assign sel         = bus_addr[STRIDE_LSB +: CH_W];
  assign sel_ok      = (int'(sel) < NUM_CH);
  assign unused_addr = ^bus_addr;

  // One configuration word per channel, stored as decoded fields only
  for (genvar i = 0; i < NUM_CH; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        cfg_o[i] <= '0;
      else if (wr_en && sel == CH_W'(i))
        cfg_o[i] <= word_to_cfg(wr_data);
    end

    // R7: a zero write leaves the addressed word fully cleared
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (rst)
      (wr_en && sel == CH_W'(i) && wr_data == '0) |=> (cfg_o[i] == '0));
  end

  // Registered read; uses the word value from before any same-cycle write
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= sel_ok ? cfg_to_word(cfg_o[sel]) : '0;
  end

  // R12: read data holds without a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/qpwm_prescaler.sv
module qpwm_prescaler #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  input  logic [CNT_W-1:0] limit,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             at_lim;

  assign at_lim = (cnt_q == limit);
  assign tick_o = adv & at_lim;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (adv)
      cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
  end

  // R4: the divide count never runs past its limit
  a_r4_within_limit: assert property (@(posedge clk) disable iff (rst)
    adv |-> (cnt_q <= limit));

  // R4: every tick restarts the divide count
  a_r4_restart_on_tick: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (cnt_q == '0));

endmodule

// File: rtl/qpwm_channel.sv
module qpwm_channel
  import qpwm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  chan_cfg_t cfg_i,
  output logic      pwm_o
);

  logic              run_q;
  logic [DUTY_W-1:0] per_q;
  logic [DUTY_W-1:0] duty_s;
  logic [DIV_W-1:0]  div_s;
  logic              live;
  logic              tick;
  logic              wrap;

  assign live = run_q & cfg_i.en;

  qpwm_prescaler #(.CNT_W(DIV_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clr    (~live),
    .adv    (live),
    .limit  (div_s),
    .tick_o (tick)
  );

  assign wrap = live && tick && (per_q == {DUTY_W{1'b1}});

  // Period counter and shadow copies of duty and divide
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      per_q  <= '0;
      duty_s <= '0;
      div_s  <= '0;
    end else if (!cfg_i.en) begin
      run_q <= 1'b0;
      per_q <= '0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
      per_q  <= '0;
      duty_s <= cfg_i.duty;
      div_s  <= cfg_i.div;
    end else if (tick) begin
      per_q <= per_q + 1'b1;
      if (wrap) begin
        duty_s <= cfg_i.duty;
        div_s  <= cfg_i.div;
      end
    end
  end

  assign pwm_o = live && (per_q < duty_s);

  // R5: the period counter moves only on a divided tick
  a_r5_count_on_tick: assert property (@(posedge clk) disable iff (rst)
    (live && !tick) |=> $stable(per_q));

  // R10: a channel that starts running begins at period position zero
  a_r10_fresh_start: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> (per_q == '0));

  // R11: shadows change only at a period wrap while running
  a_r11_duty_held: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> $stable(duty_s));

  a_r11_div_held: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> $stable(div_s));

endmodule

// File: rtl/quad_pwm.sv
module quad_pwm
  import qpwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  chan_cfg_t [NUM_CH-1:0] cfg;

  qpwm_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .wr_data  (bus_wdata),
    .wr_en    (bus_we),
    .rd_en    (bus_re),
    .rd_data  (bus_rdata),
    .cfg_o    (cfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    qpwm_channel u_ch (
      .clk   (clk),
      .rst   (rst),
      .cfg_i (cfg[g]),
      .pwm_o (pwm_out[g])
    );
  end

  // R3: a channel whose enable flag is clear never drives high
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r3_off_is_low: assert property (@(posedge clk) disable iff (rst)
      !cfg[g].en |-> !pwm_out[g]);
  end

endmodule

// File: tb/quad_pwm_tb_top.sv
module quad_pwm_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  quad_pwm dut_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg [4];
  int m_run [4];
  int m_pre [4];
  int m_per [4];
  int m_duty [4];
  int m_div [4];
  logic [31:0] m_rdata;
  int hi_acc [4];

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) begin
        m_reg[c] = '0; m_run[c] = 0; m_pre[c] = 0; m_per[c] = 0;
        m_duty[c] = 0; m_div[c] = 0;
      end
      m_rdata = '0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (!m_reg[c][31]) begin
          m_run[c] = 0; m_pre[c] = 0; m_per[c] = 0;
        end else if (m_run[c] == 0) begin
          m_run[c] = 1; m_pre[c] = 0; m_per[c] = 0;
          m_duty[c] = int'(m_reg[c][23:16]);
          m_div[c]  = int'(m_reg[c][12:0]);
        end else if (m_pre[c] == m_div[c]) begin
          m_pre[c] = 0;
          if (m_per[c] == 255) begin
            m_per[c] = 0;
            m_duty[c] = int'(m_reg[c][23:16]);
            m_div[c]  = int'(m_reg[c][12:0]);
          end else begin
            m_per[c] = m_per[c] + 1;
          end
        end else begin
          m_pre[c] = m_pre[c] + 1;
        end
      end
      if (bus_re) m_rdata = m_reg[int'(bus_addr[5:4])];
      if (bus_we) m_reg[int'(bus_addr[5:4])] = bus_wdata & 32'h80FF_1FFF;
    end
  end

  // High-cycle accumulators: each posedge counts the cycle that just ended
  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 4; c++) hi_acc[c] = 0;
    end else begin
      for (int c = 0; c < 4; c++) if (pwm_out[c]) hi_acc[c] = hi_acc[c] + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int c = 0; c < 4; c++) begin
        chk("R5 per-cycle output", longint'(pwm_out[c]),
            longint'(m_reg[c][31] && m_run[c] == 1 && m_per[c] < m_duty[c]));
      end
      chk("R8 per-cycle read data", longint'(bus_rdata), longint'(m_rdata));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic measure(input int ch, input int n, output int hi);
    int s;
    s = hi_acc[ch];
    repeat (n) @(negedge clk);
    hi = hi_acc[ch] - s;
  endtask

  function automatic logic [31:0] word(input bit en, input int duty, input int div);
    return {en, 7'd0, duty[7:0], 3'd0, div[12:0]};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- directed scenarios ----------------
  initial begin
    logic [31:0] rv;
    logic [31:0] held;
    int hi;
    int s;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 outputs low after reset", longint'(pwm_out), 0);
    chk("R1 read data zero after reset", longint'(bus_rdata), 0);
    for (int c = 0; c < 4; c++) begin
      rd(6'(c * 16), rv);
      chk("R1 word zero after reset", longint'(rv), 0);
    end

    // R10/R5/R4: channel 0, divide by 1, duty 64
    wr(6'h00, word(1, 64, 0));
    chk("R10 low in the cycle after enable", longint'(pwm_out[0]), 0);
    @(negedge clk);
    chk("R10 first period starts high", longint'(pwm_out[0]), 1);
    measure(0, 256, hi);
    chk("R5 duty 64 divide 0 high cycles", hi, 64);
    measure(0, 256, hi);
    chk("R4 second period same length", hi, 64);

    // R7: zero write
    wr(6'h00, 32'h0);
    chk("R7 output low after zero write", longint'(pwm_out[0]), 0);
    rd(6'h00, rv);
    chk("R7 word reads zero", longint'(rv), 0);

    // R4: channel 1, divide by 3, duty 10
    wr(6'h10, word(1, 10, 2));
    @(negedge clk);
    measure(1, 768, hi);
    chk("R4 divide 2 duty 10 high cycles", hi, 30);

    // R6: duty 0
    wr(6'h10, 32'h0);
    wr(6'h10, word(1, 0, 0));
    @(negedge clk);
    measure(1, 256, hi);
    chk("R6 duty 0 never high", hi, 0);

    // R6: duty 255
    wr(6'h20, word(1, 255, 0));
    @(negedge clk);
    measure(2, 255, hi);
    chk("R6 duty 255 high cycles", hi, 255);
    chk("R6 duty 255 last tick low", longint'(pwm_out[2]), 0);

    // R9/R2: masked bits and ignored low address bits
    wr(6'h2F, 32'hFFFF_FFFF);
    rd(6'h20, rv);
    chk("R9 unlisted bits read zero", longint'(rv), longint'(32'h80FF_1FFF));
    rd(6'h10, rv);
    chk("R2 other channel unchanged", longint'(rv), longint'(word(1, 0, 0)));

    // R3/R8: read-modify-write of enable alone
    rd(6'h20, rv);
    wr(6'h20, rv & 32'h7FFF_FFFF);
    chk("R3 output low after enable cleared", longint'(pwm_out[2]), 0);
    rd(6'h24, rv);
    chk("R8 read-back keeps duty and divide", longint'(rv), longint'(32'h00FF_1FFF));

    // R12: read data holds without a strobe
    held = bus_rdata;
    repeat (5) @(negedge clk);
    chk("R12 read data held", longint'(bus_rdata), longint'(held));

    // R11: mid-period duty change on channel 3
    wr(6'h30, word(1, 200, 0));
    @(negedge clk);
    s = hi_acc[3];
    repeat (50) @(negedge clk);
    wr(6'h30, word(1, 20, 0));
    repeat (204) @(negedge clk);
    chk("R11 current period keeps old duty", hi_acc[3] - s, 200);
    measure(3, 256, hi);
    chk("R11 next period uses new duty", hi, 20);

    // R10: restart mid-period gives a full first period
    repeat (37) @(negedge clk);
    wr(6'h30, word(0, 20, 0));
    wr(6'h30, word(1, 100, 1));
    @(negedge clk);
    measure(3, 512, hi);
    chk("R10 full first period after re-enable", hi, 200);

    // R8: read and write of same channel in one cycle returns old word
    @(negedge clk);
    bus_addr = 6'h30; bus_wdata = word(1, 7, 3); bus_we = 1'b1; bus_re = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_re = 1'b0;
    chk("R8 same-cycle read returns old word", longint'(bus_rdata),
        longint'(word(1, 100, 1)));

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule